// File: doc/BRIEF.md
# Two-Port Shared Byte Memory with Collision Arbitration and Mailboxes

This block is a clocked model of a 2048-word by 8-bit memory with two independent access ports, called left and right. Each port carries an address, write data, read data, a chip enable, a write select (1 = write, 0 = read) and an output enable. Either port can reach any word in any cycle.

When both ports address the same word in one cycle and at least one of them writes, the left port wins. The right port is told so through its busy output, and its write is dropped. Two reads of one word never conflict.

A mode input turns a copy into a slave. In slave mode each port takes its busy state from an input driven by a master copy. Master and slave copies placed side by side therefore store or drop the same writes, which lets them form a wider word. The two highest words act as mailboxes. Writing one of them raises an interrupt flag towards the opposite port, and that port clears the flag by reading the word.

Top module: `dpram_arb`

## Requirements
- R1: A word written through either port (ce=1, we=1) is returned unchanged by a later read of the same address through either port, for all 2048 addresses.
- R2: Read data appears on the port's rdata in the cycle after the read request. rdata is zero unless the previous cycle's request had ce=1, we=0 and oe=1.
- R3: Both ports may read the same address in the same cycle. Both receive the stored word, and neither busy output rises.
- R4: In master mode (slave_mode=0), r_busy_o is high in the same cycle whenever both ports are enabled on one address and at least one of them writes. l_busy_o is never high in master mode. The left write takes effect and the right write is discarded. A read that collides with a write returns the word as it was before that write.
- R5: In slave mode (slave_mode=1), each busy output follows that port's busy input, and no internal arbitration takes place. A port's write is discarded while its busy input is high. If both ports write one address with both busy inputs low, the left value is stored.
- R6: A right-port write that is not discarded, to address 0x7FF, sets l_int in the next cycle. A left read of 0x7FF clears l_int. A right read of 0x7FF does not clear it.
- R7: A left-port write that is not discarded, to address 0x7FE, sets r_int in the next cycle. A right read of 0x7FE clears r_int, and a left read does not. If a set and a clear fall in the same cycle, the set wins.
- R8: A synchronous reset (rst=1) clears l_int, r_int and both rdata buses. Memory contents survive the reset.
- R9: A port with ce=0 neither writes nor reads, and its rdata is zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slave_mode | input | 1 | 1 = busy comes from the busy inputs; 0 = internal arbitration |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_ce | input | 1 | Left chip enable |
| l_we | input | 1 | Left write select (1 = write) |
| l_oe | input | 1 | Left output enable |
| l_busy_i | input | 1 | Left busy from a master copy (slave mode only) |
| l_rdata | output | 8 | Left read data |
| l_busy_o | output | 1 | Left busy indication |
| l_int | output | 1 | Left mailbox flag (set by a right write to 0x7FF) |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_ce | input | 1 | Right chip enable |
| r_we | input | 1 | Right write select (1 = write) |
| r_oe | input | 1 | Right output enable |
| r_busy_i | input | 1 | Right busy from a master copy (slave mode only) |
| r_rdata | output | 8 | Right read data |
| r_busy_o | output | 1 | Right busy indication |
| r_int | output | 1 | Right mailbox flag (set by a left write to 0x7FE) |

## Verification
The properties assume that every input is settled and free of unknowns at each rising edge. The stimulus meets this by changing inputs only on the falling edge. The properties also assume that the busy inputs matter only in slave mode, so the stimulus holds them low outside the slave-mode section. The mailbox clear property excludes any cycle in which the opposite port is writing the same mailbox word. This lets it hold even in slave mode, where the right write is not blocked. The stimulus drives exhaustive sweeps over all addresses with both ports reading together. It then drives directed collision and mailbox sequences, and checks each against a reference array kept in the bench.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef struct packed {
    logic ce;
    logic we;
    logic oe;
  } port_ctl_t;

  localparam int NPORT = 2;
  localparam int PL = 0;
  localparam int PR = 1;
endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
  import dpram_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic      slave_mode,
  input  port_ctl_t l_ctl,
  input  port_ctl_t r_ctl,
  input  logic [AW-1:0] l_addr,
  input  logic [AW-1:0] r_addr,
  input  logic      l_busy_i,
  input  logic      r_busy_i,
  output logic      l_busy,
  output logic      r_busy,
  output logic      l_wr_en,
  output logic      r_wr_en
);
  logic same_word;
  logic clash;

  assign same_word = l_ctl.ce && r_ctl.ce && (l_addr == r_addr);
  assign clash     = same_word && (l_ctl.we || r_ctl.we);

  always_comb begin
    if (slave_mode) begin
      l_busy = l_busy_i;
      r_busy = r_busy_i;
    end else begin
      l_busy = 1'b0;
      r_busy = clash;
    end
  end

  assign l_wr_en = l_ctl.ce && l_ctl.we && !l_busy;
  assign r_wr_en = r_ctl.ce && r_ctl.we && !r_busy;
endmodule

// File: rtl/dpram_mem.sv
module dpram_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic          l_wr_en,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  input  logic          r_wr_en,
  output logic [DW-1:0] l_q,
  output logic [DW-1:0] r_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    l_q <= store[l_addr];
    r_q <= store[r_addr];
    if (r_wr_en) store[r_addr] <= r_wdata;
    if (l_wr_en) store[l_addr] <= l_wdata;
  end
endmodule

// File: rtl/dpram_rdport.sv
module dpram_rdport
  import dpram_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  port_ctl_t     ctl,
  input  logic [DW-1:0] q,
  output logic [DW-1:0] rdata
);
  logic drive_q;

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= ctl.ce && !ctl.we && ctl.oe;
  end

  assign rdata = drive_q ? q : '0;
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
  parameter int AW = 11,
  parameter logic [AW-1:0] SLOT = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          peer_wr_en,
  input  logic [AW-1:0] peer_addr,
  input  logic          own_rd,
  input  logic [AW-1:0] own_addr,
  output logic          flag
);
  logic hit_set;
  logic hit_clr;

  assign hit_set = peer_wr_en && (peer_addr == SLOT);
  assign hit_clr = own_rd && (own_addr == SLOT);

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (hit_set) flag <= 1'b1;
    else if (hit_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
  import dpram_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slave_mode,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic          l_ce,
  input  logic          l_we,
  input  logic          l_oe,
  input  logic          l_busy_i,
  output logic [DW-1:0] l_rdata,
  output logic          l_busy_o,
  output logic          l_int,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  input  logic          r_ce,
  input  logic          r_we,
  input  logic          r_oe,
  input  logic          r_busy_i,
  output logic [DW-1:0] r_rdata,
  output logic          r_busy_o,
  output logic          r_int
);
  localparam logic [AW-1:0] TOP_WORD = '1;

  port_ctl_t     ctl    [NPORT];
  logic [AW-1:0] addr_a [NPORT];
  logic [DW-1:0] q_a    [NPORT];
  logic [DW-1:0] rd_a   [NPORT];
  logic          wr_en  [NPORT];
  logic          flag_a [NPORT];

  assign ctl[PL]    = '{ce: l_ce, we: l_we, oe: l_oe};
  assign ctl[PR]    = '{ce: r_ce, we: r_we, oe: r_oe};
  assign addr_a[PL] = l_addr;
  assign addr_a[PR] = r_addr;

  dpram_arbiter #(.AW(AW)) u_arb (
    .slave_mode (slave_mode),
    .l_ctl      (ctl[PL]),
    .r_ctl      (ctl[PR]),
    .l_addr     (l_addr),
    .r_addr     (r_addr),
    .l_busy_i   (l_busy_i),
    .r_busy_i   (r_busy_i),
    .l_busy     (l_busy_o),
    .r_busy     (r_busy_o),
    .l_wr_en    (wr_en[PL]),
    .r_wr_en    (wr_en[PR])
  );

  dpram_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .l_addr  (l_addr),
    .l_wdata (l_wdata),
    .l_wr_en (wr_en[PL]),
    .r_addr  (r_addr),
    .r_wdata (r_wdata),
    .r_wr_en (wr_en[PR]),
    .l_q     (q_a[PL]),
    .r_q     (q_a[PR])
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [AW-1:0] SLOT = TOP_WORD - AW'(p);

    dpram_rdport #(.DW(DW)) u_rd (
      .clk   (clk),
      .rst   (rst),
      .ctl   (ctl[p]),
      .q     (q_a[p]),
      .rdata (rd_a[p])
    );

    dpram_mailbox #(.AW(AW), .SLOT(SLOT)) u_mbox (
      .clk        (clk),
      .rst        (rst),
      .peer_wr_en (wr_en[NPORT-1-p]),
      .peer_addr  (addr_a[NPORT-1-p]),
      .own_rd     (ctl[p].ce && !ctl[p].we),
      .own_addr   (addr_a[p]),
      .flag       (flag_a[p])
    );
  end

  assign l_rdata = rd_a[PL];
  assign r_rdata = rd_a[PR];
  assign l_int   = flag_a[PL];
  assign r_int   = flag_a[PR];
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          slave_mode,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_wdata,
  input logic          l_ce,
  input logic          l_we,
  input logic          l_oe,
  input logic          l_busy_i,
  input logic [DW-1:0] l_rdata,
  input logic          l_busy_o,
  input logic          l_int,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_wdata,
  input logic          r_ce,
  input logic          r_we,
  input logic          r_oe,
  input logic          r_busy_i,
  input logic [DW-1:0] r_rdata,
  input logic          r_busy_o,
  input logic          r_int
);
  localparam logic [AW-1:0] L_SLOT = '1;
  localparam logic [AW-1:0] R_SLOT = L_SLOT - AW'(1);

  // R4
  master_left_free_chk: assert property (@(posedge clk) disable iff (rst)
    !slave_mode |-> !l_busy_o);

  // R3
  dual_read_free_chk: assert property (@(posedge clk) disable iff (rst)
    (!slave_mode && l_ce && r_ce && !l_we && !r_we && l_addr == r_addr)
      |-> (!l_busy_o && !r_busy_o));

  // R5
  slave_follow_chk: assert property (@(posedge clk) disable iff (rst)
    slave_mode |-> (l_busy_o == l_busy_i && r_busy_o == r_busy_i));

  // R9
  idle_left_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !l_ce |=> l_rdata == '0);

  // R9
  idle_right_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !r_ce |=> r_rdata == '0);

  // R6
  left_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (r_ce && r_we && !r_busy_o && r_addr == L_SLOT) |=> l_int);

  // R6
  left_flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (l_ce && !l_we && l_addr == L_SLOT && !(r_ce && r_we && r_addr == L_SLOT))
      |=> !l_int);

  // R7
  right_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (l_ce && l_we && !l_busy_o && l_addr == R_SLOT) |=> r_int);

  // R7
  right_flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (r_ce && !r_we && r_addr == R_SLOT && !(l_ce && l_we && l_addr == R_SLOT))
      |=> !r_int);

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!l_int && !r_int && l_rdata == '0 && r_rdata == '0));
endmodule

bind dpram_arb dpram_arb_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/dpram_arb_tb.sv
module dpram_arb_tb;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] L_SLOT = 11'h7FF;
  localparam logic [AW-1:0] R_SLOT = 11'h7FE;

  logic clk = 1'b0;
  logic rst, slave_mode;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_ce, l_we, l_oe, l_busy_i, l_busy_o, l_int;
  logic r_ce, r_we, r_oe, r_busy_i, r_busy_o, r_int;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #10 clk = ~clk;

  dpram_arb #(.AW(AW), .DW(DW)) u_dut (.*);

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'((a * 37 + (a >> 8) + salt * 101) & 8'hFF);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic idle_all();
    l_ce = 0; l_we = 0; l_oe = 0; l_addr = '0; l_wdata = '0;
    r_ce = 0; r_we = 0; r_oe = 0; r_addr = '0; r_wdata = '0;
  endtask

  task automatic drv_l(bit ce, bit we, bit oe, int a, int d);
    l_ce = ce; l_we = we; l_oe = oe; l_addr = AW'(a); l_wdata = DW'(d);
  endtask

  task automatic drv_r(bit ce, bit we, bit oe, int a, int d);
    r_ce = ce; r_we = we; r_oe = oe; r_addr = AW'(a); r_wdata = DW'(d);
  endtask

  task automatic do_reset();
    idle_all();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    slave_mode = 0; l_busy_i = 0; r_busy_i = 0;
    do_reset();
    // R8 reset state
    chk(l_rdata == 0 && r_rdata == 0, "R8 rdata", {l_rdata, r_rdata}, 0);
    chk(!l_int && !r_int, "R8 int", {l_int, r_int}, 0);
    chk(!l_busy_o && !r_busy_o, "R4 idle busy", {l_busy_o, r_busy_o}, 0);

    // R1 sweep left writes over all addresses
    for (int a = 0; a < DEPTH; a++) begin
      drv_l(1, 1, 0, a, pat(a, 0));
      ref_mem[a] = pat(a, 0);
      @(negedge clk);
    end
    do_reset();
    // R8 flags cleared, memory retained (checked by the sweep below)
    chk(!r_int && !l_int, "R8 int after sweep", {l_int, r_int}, 0);

    // R3 + R1: both ports read every address together
    for (int a = 0; a < DEPTH; a++) begin
      drv_l(1, 0, 1, a, 0);
      drv_r(1, 0, 1, a, 0);
      #1;
      chk(!l_busy_o && !r_busy_o, "R3 busy", {l_busy_o, r_busy_o}, 0);
      @(negedge clk);
      chk(r_rdata == ref_mem[a], "R1 right read", r_rdata, ref_mem[a]);
      chk(l_rdata == ref_mem[a], "R3 left read", l_rdata, ref_mem[a]);
    end
    idle_all();

    // R1 right writes, left reads back
    for (int a = 0; a < 1024; a++) begin
      drv_r(1, 1, 0, a, pat(a, 1));
      ref_mem[a] = pat(a, 1);
      @(negedge clk);
    end
    idle_all();
    for (int a = 0; a < 1024; a++) begin
      drv_l(1, 0, 1, a, 0);
      @(negedge clk);
      chk(l_rdata == ref_mem[a], "R1 left read", l_rdata, ref_mem[a]);
    end
    idle_all();

    // R2 gating of rdata
    drv_l(1, 0, 0, 10, 0); @(negedge clk);
    chk(l_rdata == 0, "R2 oe low", l_rdata, 0);
    drv_l(1, 1, 1, 10, ref_mem[10]); @(negedge clk);
    chk(l_rdata == 0, "R2 write cycle", l_rdata, 0);
    drv_l(1, 0, 1, 10, 0); @(negedge clk);
    chk(l_rdata == ref_mem[10], "R2 read latency", l_rdata, ref_mem[10]);

    // R9 disabled port
    drv_l(0, 1, 1, 5, 8'hC3); drv_r(0, 0, 1, 5, 0); @(negedge clk);
    chk(l_rdata == 0 && r_rdata == 0, "R9 rdata", {l_rdata, r_rdata}, 0);
    drv_l(1, 0, 1, 5, 0); idle_all(); drv_l(1, 0, 1, 5, 0); @(negedge clk);
    chk(l_rdata == ref_mem[5], "R9 no write", l_rdata, ref_mem[5]);
    idle_all();

    // R4 write/write collision
    drv_l(1, 1, 0, 100, 8'hA5); drv_r(1, 1, 0, 100, 8'h5A); #1;
    chk(r_busy_o && !l_busy_o, "R4 ww busy", {l_busy_o, r_busy_o}, 1);
    @(negedge clk); ref_mem[100] = 8'hA5;
    idle_all(); drv_r(1, 0, 1, 100, 0); @(negedge clk);
    chk(r_rdata == 8'hA5, "R4 ww result", r_rdata, 8'hA5);
    // R4 left write / right read
    drv_l(1, 1, 0, 100, 8'h3C); drv_r(1, 0, 1, 100, 0); #1;
    chk(r_busy_o && !l_busy_o, "R4 wr busy", {l_busy_o, r_busy_o}, 1);
    @(negedge clk); ref_mem[100] = 8'h3C;
    chk(r_rdata == 8'hA5, "R4 old data", r_rdata, 8'hA5);
    // R4 right write / left read: right write dropped
    drv_l(1, 0, 1, 100, 0); drv_r(1, 1, 0, 100, 8'h77); #1;
    chk(r_busy_o && !l_busy_o, "R4 rw busy", {l_busy_o, r_busy_o}, 1);
    @(negedge clk);
    chk(l_rdata == 8'h3C, "R4 left read", l_rdata, 8'h3C);
    idle_all(); drv_l(1, 0, 1, 100, 0); @(negedge clk);
    chk(l_rdata == 8'h3C, "R4 right dropped", l_rdata, 8'h3C);
    idle_all();

    // R5 slave mode
    slave_mode = 1; r_busy_i = 1;
    drv_r(1, 1, 0, 200, 8'hEE); #1;
    chk(r_busy_o && !l_busy_o, "R5 follow", {l_busy_o, r_busy_o}, 1);
    @(negedge clk);
    r_busy_i = 0; l_busy_i = 1; idle_all();
    drv_l(1, 1, 0, 201, 8'hDD); #1;
    chk(l_busy_o && !r_busy_o, "R5 follow left", {l_busy_o, r_busy_o}, 2);
    @(negedge clk);
    l_busy_i = 0; idle_all();
    drv_l(1, 1, 0, 202, 8'h11); drv_r(1, 1, 0, 202, 8'h22); #1;
    chk(!l_busy_o && !r_busy_o, "R5 no arb", {l_busy_o, r_busy_o}, 0);
    @(negedge clk); ref_mem[202] = 8'h11;
    slave_mode = 0; idle_all();
    for (int a = 200; a < 203; a++) begin
      drv_r(1, 0, 1, a, 0); @(negedge clk);
      chk(r_rdata == ref_mem[a], "R5 stored", r_rdata, ref_mem[a]);
    end
    idle_all();

    // R6 left mailbox
    drv_r(1, 1, 0, L_SLOT, 8'h99); @(negedge clk); ref_mem[L_SLOT] = 8'h99;
    chk(l_int && !r_int, "R6 set", {l_int, r_int}, 2);
    idle_all(); drv_r(1, 0, 1, L_SLOT, 0); @(negedge clk);
    chk(l_int, "R6 right read keeps", l_int, 1);
    idle_all(); drv_l(1, 0, 1, L_SLOT, 0); @(negedge clk);
    chk(!l_int, "R6 clear", l_int, 0);
    chk(l_rdata == 8'h99, "R6 data", l_rdata, 8'h99);
    idle_all();

    // R7 right mailbox
    drv_l(1, 1, 0, R_SLOT, 8'h66); @(negedge clk); ref_mem[R_SLOT] = 8'h66;
    chk(r_int && !l_int, "R7 set", {l_int, r_int}, 1);
    idle_all(); drv_l(1, 0, 1, R_SLOT, 0); @(negedge clk);
    chk(r_int, "R7 left read keeps", r_int, 1);
    idle_all(); drv_r(1, 0, 1, R_SLOT, 0); @(negedge clk);
    chk(!r_int, "R7 clear", r_int, 0);
    chk(r_rdata == 8'h66, "R7 data", r_rdata, 8'h66);
    // R7 set wins over a same-cycle clear
    drv_l(1, 1, 0, R_SLOT, 8'h44); drv_r(1, 0, 1, R_SLOT, 0); @(negedge clk);
    chk(r_int, "R7 set wins", r_int, 1);
    chk(r_rdata == 8'h66, "R7 old data", r_rdata, 8'h66);
    idle_all(); @(negedge clk);

    finish_up();
  end
endmodule